// File: doc/BRIEF.md
# Decode-Issue Stall Controller

This block is the front end of one core. It owns the instruction index that selects the next instruction to fetch. It also holds one decoded instruction at a time in a single issue slot. Each decoded word carries four things: a unit-type tag, a signed index step, an end-of-stream flag and an opaque payload. Branches and jumps have already been resolved when the word arrives. A taken branch carries its signed offset as the step, and a branch that is not taken carries a step of one.

Every cycle the controller decides whether the front end stalls. It stalls once the stream has ended, or whenever any execute unit raises its conflict line. When it does not stall, the held instruction is offered on a per-unit lane. Only the lane of the unit whose type matches the tag carries a valid flag and the payload, and every other lane reads zero. Execution starts only in a cycle where the matched lane is valid and that unit is ready.

On that start, three things happen together: the index moves by the step, the slot empties, and a new word may be taken on the next cycle. The core reports done once the stream has ended and every unit reports it has drained.

The decoded-word input is a valid/ready stream. The source keeps `dec_valid` high and all word fields unchanged until a cycle in which `dec_ready` is high. `dec_ready` is low while the slot is occupied or after the stream has ended. The per-unit issue lanes follow the same rule: a lane's valid and payload stay unchanged until that unit's ready is seen high with them, or until a conflict withdraws the valid flag.

Top module: `issue_stall_ctrl`

## Requirements
- R1: After a synchronous active-high reset:
  - `fetch_idx` is 0.
  - All `iss_valid` bits and all `iss_data` lanes are 0.
  - `dec_ready` is 1.
  - `core_done` is 0.
- R2: `dec_ready` is 1 exactly when the slot is empty and the stream has not ended. A word is taken on a rising edge where `dec_valid` and `dec_ready` are both 1.
- R3: While the slot is occupied and the instruction has not started, the lane payload stays unchanged.
- R4: While any bit of `unit_conflict` is 1, every `iss_valid` bit is 0 and `fetch_idx` does not change.
- R5: With the slot occupied and no stall, `iss_valid` is one-hot, with bit k set where k equals the 2-bit-per-default `dec_unit` tag of the held word.
- R6: Lane k of `iss_data` (bits k*DATA_W up to k*DATA_W+DATA_W-1) carries the held payload when k matches the tag. Every other lane is zero.
- R7: An instruction starts on a rising edge where `iss_valid[k]` and `unit_ready[k]` are both 1. While the target is not ready, nothing starts and `fetch_idx` holds.
- R8: When an instruction starts, `fetch_idx` becomes its previous value plus the sign-extended `dec_inc`, wrapping modulo 2^IDX_W. This allows backward steps.
- R9: In the cycle an instruction starts, `dec_ready` is still 0. In the following cycle the slot is empty, `dec_ready` is 1 (unless the stream ended) and `iss_valid` is 0.
- R10: Once a word with `dec_last` = 1 has started, the stream has ended:
  - `dec_ready` stays 0.
  - No `iss_valid` bit rises.
  - `fetch_idx` holds until reset.
- R11: `core_done` is 1 exactly when the stream has ended and every `unit_done` bit is 1. Units reporting done before the stream ends do not raise it.
- R12: A reset in mid-stream, with the slot occupied, clears the index, the slot and the end-of-stream state. Afterwards the controller takes a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_idx | output | IDX_W | Index of the instruction to fetch and decode |
| dec_valid | input | 1 | Decoded word present |
| dec_ready | output | 1 | Slot can take a word |
| dec_unit | input | UT_W | Target unit-type tag |
| dec_inc | input | INC_W | Signed index step resolved at decode |
| dec_last | input | 1 | Word is the final one of the stream |
| dec_data | input | DATA_W | Opaque payload for the execute unit |
| unit_conflict | input | UNITS | Per-unit resource conflict |
| unit_ready | input | UNITS | Per-unit ready to start |
| iss_valid | output | UNITS | One-hot issue enable per unit |
| iss_data | output | UNITS*DATA_W | Per-unit payload lanes, zero when not targeted |
| unit_done | input | UNITS | Per-unit drained indication |
| core_done | output | 1 | Stream ended and all units drained |

## Verification
The embedded checks assume three things about the inputs:
- A waiting source holds `dec_valid` high and all word fields steady until it sees `dec_ready`.
- Every tag is below the unit count.
- `fetch_idx` has no effect on `dec_inc` inside a cycle.

The stimulus raises `dec_valid` only in cycles where `dec_ready` is known to be high, except in the end-of-stream test. There it presents one fixed word and keeps it steady until reset. Tags are drawn only from 0 to 3, and conflicts and readiness are driven as free per-unit patterns. That includes ready units that are in conflict, so the conflict gate is exercised apart from readiness.

// File: rtl/isc_pkg.sv
package isc_pkg;

  // Occupancy of the single issue slot; SLOT_FIN marks an ended stream.
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_HELD  = 2'd1,
    SLOT_FIN   = 2'd2
  } slot_e;

  localparam int DEF_UNITS  = 4;
  localparam int DEF_IDX_W  = 16;
  localparam int DEF_INC_W  = 8;
  localparam int DEF_DATA_W = 32;

endpackage

// File: rtl/isc_slot.sv
module isc_slot
  import isc_pkg::*;
#(
  parameter int UT_W   = 2,
  parameter int INC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [UT_W-1:0]         in_unit,
  input  logic signed [INC_W-1:0] in_inc,
  input  logic                    in_last,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    start,
  output logic                    held,
  output logic                    fin,
  output logic [UT_W-1:0]         out_unit,
  output logic signed [INC_W-1:0] out_inc,
  output logic [DATA_W-1:0]       out_data
);

  slot_e               state_q;
  logic                last_q;
  logic                take;

  assign in_ready = (state_q == SLOT_EMPTY);
  assign take     = in_valid && in_ready;
  assign held     = (state_q == SLOT_HELD);
  assign fin      = (state_q == SLOT_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SLOT_EMPTY;
      last_q   <= 1'b0;
      out_unit <= '0;
      out_inc  <= '0;
      out_data <= '0;
    end else begin
      unique case (state_q)
        SLOT_EMPTY: if (take) state_q <= SLOT_HELD;
        SLOT_HELD:  if (start) state_q <= last_q ? SLOT_FIN : SLOT_EMPTY;
        default:    state_q <= SLOT_FIN;
      endcase
      if (take) begin
        out_unit <= in_unit;
        out_inc  <= in_inc;
        out_data <= in_data;
        last_q   <= in_last;
      end
    end
  end

  // R2
  accept_load_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> held);

  // R3
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (held && !start) |=> (held && $stable(out_data) && $stable(out_unit)));

  // R10
  fin_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> (fin && !in_ready));

endmodule

// File: rtl/isc_index.sv
module isc_index #(
  parameter int IDX_W = 16,
  parameter int INC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic signed [INC_W-1:0] step,
  output logic [IDX_W-1:0]        idx
);

  logic [IDX_W-1:0] step_ext;

  assign step_ext = IDX_W'(step);

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= idx + step_ext;
  end

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (idx == '0));

endmodule

// File: rtl/isc_route.sv
module isc_route #(
  parameter int UNITS  = 4,
  parameter int UT_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    held,
  input  logic                    stall,
  input  logic [UT_W-1:0]         unit,
  input  logic [DATA_W-1:0]       data,
  output logic [UNITS-1:0]        lane_valid,
  output logic [UNITS*DATA_W-1:0] lane_data
);

  for (genvar u = 0; u < UNITS; u++) begin : g_lane
    logic hit;
    assign hit           = held && (unit == UT_W'(u));
    assign lane_valid[u] = hit && !stall;
    assign lane_data[u*DATA_W +: DATA_W] = hit ? data : '0;
  end

  // R5
  issue_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_valid));

  // R6
  lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !held |-> (lane_data == '0));

endmodule

// File: rtl/issue_stall_ctrl.sv
module issue_stall_ctrl
  import isc_pkg::*;
#(
  parameter int UNITS  = DEF_UNITS,
  parameter int IDX_W  = DEF_IDX_W,
  parameter int INC_W  = DEF_INC_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int UT_W  = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [IDX_W-1:0]        fetch_idx,
  input  logic                    dec_valid,
  output logic                    dec_ready,
  input  logic [UT_W-1:0]         dec_unit,
  input  logic [INC_W-1:0]        dec_inc,
  input  logic                    dec_last,
  input  logic [DATA_W-1:0]       dec_data,
  input  logic [UNITS-1:0]        unit_conflict,
  input  logic [UNITS-1:0]        unit_ready,
  output logic [UNITS-1:0]        iss_valid,
  output logic [UNITS*DATA_W-1:0] iss_data,
  input  logic [UNITS-1:0]        unit_done,
  output logic                    core_done
);

  logic                    held;
  logic                    fin;
  logic                    stall;
  logic                    start;
  logic [UT_W-1:0]         h_unit;
  logic signed [INC_W-1:0] h_inc;
  logic [DATA_W-1:0]       h_data;

  assign stall     = fin || (|unit_conflict);
  assign start     = |(iss_valid & unit_ready);
  assign core_done = fin && (&unit_done);

  isc_slot #(.UT_W(UT_W), .INC_W(INC_W), .DATA_W(DATA_W)) slot_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (dec_valid),
    .in_ready (dec_ready),
    .in_unit  (dec_unit),
    .in_inc   ($signed(dec_inc)),
    .in_last  (dec_last),
    .in_data  (dec_data),
    .start    (start),
    .held     (held),
    .fin      (fin),
    .out_unit (h_unit),
    .out_inc  (h_inc),
    .out_data (h_data)
  );

  isc_index #(.IDX_W(IDX_W), .INC_W(INC_W)) index_i (
    .clk  (clk),
    .rst  (rst),
    .adv  (start),
    .step (h_inc),
    .idx  (fetch_idx)
  );

  isc_route #(.UNITS(UNITS), .UT_W(UT_W), .DATA_W(DATA_W)) route_i (
    .clk        (clk),
    .rst        (rst),
    .held       (held),
    .stall      (stall),
    .unit       (h_unit),
    .data       (h_data),
    .lane_valid (iss_valid),
    .lane_data  (iss_data)
  );

  // R2
  dec_hold_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_data) && $stable(dec_unit)));

  // R5
  unit_tag_range_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (int'(dec_unit) < UNITS));

  // R4
  conflict_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (|unit_conflict) |-> (iss_valid == '0));

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(iss_valid & unit_ready)) |=> $stable(fetch_idx));

  // R10
  end_stall_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> (!dec_ready && (iss_valid == '0)));

  // R11
  done_needs_all_chk: assert property (@(posedge clk) disable iff (rst)
    core_done |-> (&unit_done));

endmodule

// File: tb/issue_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module issue_stall_ctrl_tb_top;

  localparam int UNITS  = 4;
  localparam int IDX_W  = 16;
  localparam int INC_W  = 8;
  localparam int DATA_W = 32;
  localparam int NVEC   = 8;

  typedef struct packed {
    logic [1:0]        unit;
    logic [INC_W-1:0]  inc;
    logic [UNITS-1:0]  conf;
    logic [1:0]        ncon;
    logic [1:0]        nwait;
    logic [DATA_W-1:0] data;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{2'd0, 8'h01, 4'b0000, 2'd0, 2'd0, 32'hA0A0_0001},
    '{2'd1, 8'h04, 4'b0100, 2'd2, 2'd1, 32'hB1B1_0002},
    '{2'd2, 8'hFD, 4'b0001, 2'd1, 2'd0, 32'hC2C2_0003},
    '{2'd3, 8'h01, 4'b0000, 2'd0, 2'd3, 32'hD3D3_0004},
    '{2'd0, 8'hF8, 4'b0010, 2'd1, 2'd1, 32'hE4E4_0005},
    '{2'd1, 8'h7F, 4'b1000, 2'd3, 2'd2, 32'hF5F5_0006},
    '{2'd2, 8'h80, 4'b0000, 2'd0, 2'd1, 32'h0606_0007},
    '{2'd3, 8'h02, 4'b0010, 2'd1, 2'd0, 32'h1717_0008}
  };

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [IDX_W-1:0]        fetch_idx;
  logic                    dec_valid = 1'b0;
  logic                    dec_ready;
  logic [1:0]              dec_unit = '0;
  logic [INC_W-1:0]        dec_inc = '0;
  logic                    dec_last = 1'b0;
  logic [DATA_W-1:0]       dec_data = '0;
  logic [UNITS-1:0]        unit_conflict = '0;
  logic [UNITS-1:0]        unit_ready = '0;
  logic [UNITS-1:0]        iss_valid;
  logic [UNITS*DATA_W-1:0] iss_data;
  logic [UNITS-1:0]        unit_done = '0;
  logic                    core_done;

  int n_chk  = 0;
  int n_fail = 0;
  logic [IDX_W-1:0]        exp_idx = '0;
  logic [UNITS*DATA_W-1:0] exp_lanes;
  logic [UNITS-1:0]        oh;

  always #2 clk = ~clk;

  issue_stall_ctrl dut_i (
    .clk(clk), .rst(rst), .fetch_idx(fetch_idx),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_unit(dec_unit),
    .dec_inc(dec_inc), .dec_last(dec_last), .dec_data(dec_data),
    .unit_conflict(unit_conflict), .unit_ready(unit_ready),
    .iss_valid(iss_valid), .iss_data(iss_data),
    .unit_done(unit_done), .core_done(core_done)
  );

  task automatic chk(input string tag, input logic [UNITS*DATA_W-1:0] act,
                     input logic [UNITS*DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [1:0] u, input logic [INC_W-1:0] inc,
                         input logic last, input logic [DATA_W-1:0] d);
    dec_valid = 1'b1;
    dec_unit  = u;
    dec_inc   = inc;
    dec_last  = last;
    dec_data  = d;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R1 idx",     fetch_idx, 0);
    chk("R1 valid",   iss_valid, 0);
    chk("R1 lanes",   iss_data, 0);
    chk("R1 ready",   dec_ready, 1);
    chk("R1 done",    core_done, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      oh = UNITS'(1) << TBL[k].unit;
      exp_lanes = '0;
      exp_lanes[TBL[k].unit*DATA_W +: DATA_W] = TBL[k].data;
      @(negedge clk);
      present(TBL[k].unit, TBL[k].inc, 1'b0, TBL[k].data);
      unit_ready = '0;
      #1;
      chk("R2 ready before take", dec_ready, 1);
      chk("R8 idx before take", fetch_idx, exp_idx);
      for (int c = 0; c < int'(TBL[k].ncon); c++) begin
        @(negedge clk);
        dec_valid = 1'b0;
        unit_conflict = TBL[k].conf;
        unit_ready = '1;
        #1;
        chk("R4 conflict gates issue", iss_valid, 0);
        chk("R4 conflict holds idx", fetch_idx, exp_idx);
        chk("R6 lane while stalled", iss_data, exp_lanes);
        chk("R2 busy slot", dec_ready, 0);
      end
      for (int w = 0; w < int'(TBL[k].nwait); w++) begin
        @(negedge clk);
        dec_valid = 1'b0;
        unit_conflict = '0;
        unit_ready = ~oh;
        #1;
        chk("R5 onehot waiting", iss_valid, oh);
        chk("R7 not ready holds idx", fetch_idx, exp_idx);
      end
      @(negedge clk);
      dec_valid = 1'b0;
      unit_conflict = '0;
      unit_ready = '1;
      #1;
      chk("R5 onehot start", iss_valid, oh);
      chk("R3 payload held", iss_data, exp_lanes);
      chk("R9 no take in start cycle", dec_ready, 0);
      exp_idx = exp_idx + IDX_W'($signed(TBL[k].inc));
      @(negedge clk);
      unit_ready = '0;
      #1;
      chk("R8 idx stepped", fetch_idx, exp_idx);
      chk("R9 slot free", dec_ready, 1);
      chk("R9 valid dropped", iss_valid, 0);
    end

    // R11: units done early do not count before the stream ends
    @(negedge clk);
    unit_done = '1;
    #1;
    chk("R11 early unit done", core_done, 0);

    // R10: final word ends the stream
    @(negedge clk);
    unit_done = '0;
    present(2'd2, 8'h01, 1'b1, 32'h5555_AAAA);
    @(negedge clk);
    dec_valid = 1'b0;
    unit_ready = '1;
    #1;
    chk("R10 last word issues", iss_valid, 4'b0100);
    exp_idx = exp_idx + 1;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      present(2'd1, 8'h03, 1'b0, 32'h0BAD_0BAD);
      unit_ready = '1;
      #1;
      chk("R10 ready stays low", dec_ready, 0);
      chk("R10 no issue", iss_valid, 0);
      chk("R10 idx frozen", fetch_idx, exp_idx);
    end
    unit_done = 4'b0111;
    #1;
    chk("R11 one unit busy", core_done, 0);
    unit_done = 4'b1111;
    #1;
    chk("R11 all drained", core_done, 1);

    // R12: reset after end of stream, then reset with slot occupied
    @(negedge clk);
    rst = 1'b1;
    dec_valid = 1'b0;
    @(negedge clk);
    #1;
    chk("R12 idx cleared", fetch_idx, 0);
    chk("R12 ready restored", dec_ready, 1);
    chk("R12 done cleared", core_done, 0);
    rst = 1'b0;
    unit_ready = '0;
    present(2'd1, 8'h05, 1'b0, 32'h1234_5678);
    @(negedge clk);
    dec_valid = 1'b0;
    #1;
    chk("R12 held before reset", iss_valid, 4'b0010);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R12 valid cleared", iss_valid, 0);
    chk("R12 lanes cleared", iss_data, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R12 takes again", dec_ready, 1);
    chk("R12 idx zero", fetch_idx, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule